// File: doc/BRIEF.md
# DRAM CKE Power-Up Sequencer

This block times the window that precedes DRAM initialization. When software reset is released, it keeps the clock-enable output low for a programmed number of 1024-cycle units. It then raises clock enable and waits a second programmed number of 1024-cycle units. At the end of that wait it sends a one-cycle start pulse to the initialization engine downstream. From the cycle after the pulse, a done flag stays high until the next software reset.

Three values are sampled once, in the first cycle in which software reset is seen low: the two delays and a 4-bit burst-length code. The block publishes the burst length that the code decodes to. A code outside the legal set raises a sticky error flag. In that case clock enable still rises, but the block stays in the second wait phase and never issues the start pulse. A hardware reset loads default values (pre 3, post 2, code 0100). If no software reset ever occurs, the sequence runs with those defaults.

Top module: `cke_powerup_seq`

## Requirements
- R1: While `rst` is high, and in the cycle after it: `cke`, `init_start`, `init_done` and `config_error` are 0 and `burst_len` is 8.
- R2: T0 is the first rising edge at which the block, idle, samples `sw_rst` low. `cke` goes high at edge T0 + pre·1024 and is low before that.
- R3: `init_start` goes high at edge T0 + P + post·1024, where P is the length of the pre phase.
- R4: A delay value of 0 makes its phase last exactly one clock cycle.
- R5: `init_start` is high for exactly one cycle. `init_done` rises at the next edge and stays high until `sw_rst`.
- R6: From edge T0, `burst_len` shows the decoded code: 0010 gives 4, 0100 gives 8, 1000 gives 16.
- R7: Any other code sets `config_error` and `burst_len` = 0 at T0. `cke` still rises per R2. `init_start` never pulses, and the error holds until `sw_rst`.
- R8: Changes on the configuration inputs after T0 have no effect on timing, burst length or error.
- R9: If `sw_rst` is sampled high at any edge, then from that edge `cke`, `init_start`, `init_done` and `config_error` are 0. This holds even when that edge is the one at which the start pulse would have fired.
- R10: After a hardware reset with no software reset, the release edge of `rst` acts as T0 and the stored defaults pre 3, post 2 and code 0100 are used.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous active-high hardware reset |
| sw_rst | input | 1 | Software reset; its release starts the sequence |
| cfg_pre_units | input | 10 | Delay before clock enable, in 1024-cycle units |
| cfg_post_units | input | 10 | Delay after clock enable, in 1024-cycle units |
| cfg_bl_code | input | 4 | Burst-length code |
| cke | output | 1 | DRAM clock enable |
| init_start | output | 1 | One-cycle start pulse to the initialization engine |
| init_done | output | 1 | High after the start pulse until software reset |
| config_error | output | 1 | Sticky flag for an illegal burst-length code |
| burst_len | output | 5 | Decoded burst length, or 0 when the code is illegal |

## Verification
The delicate collision is a software reset that lands on the same edge at which the post phase expires and the start pulse would fire. The bench releases software reset with a zero pre delay and a one-unit post delay, so that this edge is known exactly. It then raises `sw_rst` so that the reset is sampled on that edge. It expects `init_start`, `init_done` and `cke` all low after the edge, and afterwards a clean restart.

// File: rtl/cke_seq_pkg.sv
package cke_seq_pkg;
  localparam int CODE_W = 4;
  localparam int BL_W   = 5;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_PRE,
    ST_POST,
    ST_DONE
  } seq_state_t;

  // legal burst codes map to 4, 8 or 16; anything else yields 0
  function automatic logic [BL_W-1:0] bl_decode(input logic [CODE_W-1:0] code);
    case (code)
      4'b0010: return 5'd4;
      4'b0100: return 5'd8;
      4'b1000: return 5'd16;
      default: return '0;
    endcase
  endfunction
endpackage

// File: rtl/cke_cfg_capture.sv
module cke_cfg_capture #(
  parameter int DLY_W = 10,
  parameter int CODE_W = 4,
  parameter logic [DLY_W-1:0] PRE_DEF = 3,
  parameter logic [DLY_W-1:0] POST_DEF = 2,
  parameter logic [CODE_W-1:0] CODE_DEF = 4'b0100
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              capture,
  input  logic [DLY_W-1:0]  pre_in,
  input  logic [DLY_W-1:0]  post_in,
  input  logic [CODE_W-1:0] code_in,
  output logic [DLY_W-1:0]  pre_q,
  output logic [DLY_W-1:0]  post_q,
  output logic [CODE_W-1:0] code_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      pre_q  <= PRE_DEF;
      post_q <= POST_DEF;
      code_q <= CODE_DEF;
    end else if (capture) begin
      pre_q  <= pre_in;
      post_q <= post_in;
      code_q <= code_in;
    end
  end
endmodule

// File: rtl/cke_delay_counter.sv
module cke_delay_counter #(
  parameter int UNITS_W = 10,
  parameter int UNIT_LOG2 = 10
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               clr,
  input  logic               load,
  input  logic [UNITS_W-1:0] units,
  input  logic               run,
  output logic               zero
);
  localparam int CNT_W = UNITS_W + UNIT_LOG2;

  logic [CNT_W-1:0] rem;
  logic [CNT_W-1:0] load_val;

  // phase length is units*2^UNIT_LOG2 cycles, minimum one cycle
  always_comb begin
    if (units == '0)
      load_val = '0;
    else
      load_val = {units, {UNIT_LOG2{1'b0}}} - {{(CNT_W-1){1'b0}}, 1'b1};
  end

  always_ff @(posedge clk) begin
    if (rst || clr)
      rem <= '0;
    else if (load)
      rem <= load_val;
    else if (run && (rem != '0))
      rem <= rem - {{(CNT_W-1){1'b0}}, 1'b1};
  end

  assign zero = (rem == '0);
endmodule

// File: rtl/cke_bl_decoder.sv
module cke_bl_decoder
  import cke_seq_pkg::*;
(
  input  logic [CODE_W-1:0] code,
  output logic [BL_W-1:0]   bl,
  output logic              legal
);
  always_comb begin
    bl    = bl_decode(code);
    legal = (bl != '0);
  end
endmodule

// File: rtl/cke_powerup_seq.sv
module cke_powerup_seq
  import cke_seq_pkg::*;
#(
  parameter int DLY_W = 10,
  parameter int UNIT_LOG2 = 10,
  parameter logic [DLY_W-1:0] PRE_DEF = 3,
  parameter logic [DLY_W-1:0] POST_DEF = 2,
  parameter logic [3:0] BL_CODE_DEF = 4'b0100
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sw_rst,
  input  logic [DLY_W-1:0] cfg_pre_units,
  input  logic [DLY_W-1:0] cfg_post_units,
  input  logic [3:0]       cfg_bl_code,
  output logic             cke,
  output logic             init_start,
  output logic             init_done,
  output logic             config_error,
  output logic [4:0]       burst_len
);
  localparam logic [BL_W-1:0] BL_RST = bl_decode(BL_CODE_DEF);

  seq_state_t        state;
  logic              armed;
  logic              go;
  logic              capture;
  logic [DLY_W-1:0]  pre_q, post_q;
  logic [CODE_W-1:0] code_q;
  logic [DLY_W-1:0]  eff_pre;
  logic [CODE_W-1:0] eff_code;
  logic [BL_W-1:0]   dec_bl;
  logic              dec_legal;
  logic              cnt_load, cnt_run, cnt_zero;
  logic [DLY_W-1:0]  cnt_units;

  // leaving idle; a preceding software reset arms a fresh sample
  assign go      = (state == ST_IDLE) && !sw_rst;
  assign capture = go && armed;

  cke_cfg_capture #(
    .DLY_W(DLY_W), .CODE_W(CODE_W),
    .PRE_DEF(PRE_DEF), .POST_DEF(POST_DEF), .CODE_DEF(BL_CODE_DEF)
  ) u_cfg (
    .clk(clk), .rst(rst), .capture(capture),
    .pre_in(cfg_pre_units), .post_in(cfg_post_units), .code_in(cfg_bl_code),
    .pre_q(pre_q), .post_q(post_q), .code_q(code_q)
  );

  assign eff_pre  = capture ? cfg_pre_units : pre_q;
  assign eff_code = capture ? cfg_bl_code : code_q;

  cke_bl_decoder u_dec (
    .code(eff_code), .bl(dec_bl), .legal(dec_legal)
  );

  always_comb begin
    cnt_load  = 1'b0;
    cnt_units = eff_pre;
    if (go) begin
      cnt_load = 1'b1;
    end else if (state == ST_PRE && cnt_zero && !sw_rst) begin
      cnt_load  = 1'b1;
      cnt_units = post_q;
    end
  end

  assign cnt_run = (state == ST_PRE) || (state == ST_POST);

  cke_delay_counter #(
    .UNITS_W(DLY_W), .UNIT_LOG2(UNIT_LOG2)
  ) u_cnt (
    .clk(clk), .rst(rst), .clr(sw_rst),
    .load(cnt_load), .units(cnt_units), .run(cnt_run), .zero(cnt_zero)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state        <= ST_IDLE;
      armed        <= 1'b0;
      cke          <= 1'b0;
      init_start   <= 1'b0;
      init_done    <= 1'b0;
      config_error <= 1'b0;
      burst_len    <= BL_RST;
    end else if (sw_rst) begin
      state        <= ST_IDLE;
      armed        <= 1'b1;
      cke          <= 1'b0;
      init_start   <= 1'b0;
      init_done    <= 1'b0;
      config_error <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          state        <= ST_PRE;
          armed        <= 1'b0;
          burst_len    <= dec_bl;
          config_error <= !dec_legal;
        end
        ST_PRE: begin
          if (cnt_zero) begin
            state <= ST_POST;
            cke   <= 1'b1;
          end
        end
        ST_POST: begin
          // an illegal code parks the sequence here
          if (cnt_zero && !config_error) begin
            state      <= ST_DONE;
            init_start <= 1'b1;
          end
        end
        ST_DONE: begin
          init_start <= 1'b0;
          init_done  <= 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/cke_powerup_seq_chk.sv
module cke_powerup_seq_chk (
  input logic       clk,
  input logic       rst,
  input logic       sw_rst,
  input logic       cke,
  input logic       init_start,
  input logic       init_done,
  input logic       config_error,
  input logic [4:0] burst_len
);
  // R9
  assert_sw_clears_R9: assert property (@(posedge clk) disable iff (rst)
    sw_rst |=> (!cke && !init_start && !init_done && !config_error));

  // R5
  assert_start_single_R5: assert property (@(posedge clk) disable iff (rst)
    init_start && !sw_rst |=> (!init_start && init_done));

  // R5
  assert_done_sticky_R5: assert property (@(posedge clk) disable iff (rst)
    init_done && !sw_rst |=> init_done);

  // R7
  assert_error_blocks_start_R7: assert property (@(posedge clk) disable iff (rst)
    config_error |-> !init_start);

  // R7
  assert_error_sticky_R7: assert property (@(posedge clk) disable iff (rst)
    config_error && !sw_rst |=> config_error);

  // R3
  assert_start_after_cke_R3: assert property (@(posedge clk) disable iff (rst)
    init_start |-> cke);

  // R2
  assert_cke_holds_R2: assert property (@(posedge clk) disable iff (rst)
    cke && !sw_rst |=> cke);

  // R6
  assert_bl_legal_R6: assert property (@(posedge clk) disable iff (rst)
    ($countones(burst_len) <= 1) && (burst_len[1:0] == 2'b00));
endmodule

bind cke_powerup_seq cke_powerup_seq_chk u_chk (
  .clk(clk), .rst(rst), .sw_rst(sw_rst), .cke(cke),
  .init_start(init_start), .init_done(init_done),
  .config_error(config_error), .burst_len(burst_len)
);

// File: tb/cke_powerup_seq_test.sv
module cke_powerup_seq_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       sw_rst = 1'b0;
  logic [9:0] cfg_pre_units = '0;
  logic [9:0] cfg_post_units = '0;
  logic [3:0] cfg_bl_code = 4'b0011;
  logic       cke, init_start, init_done, config_error;
  logic [4:0] burst_len;

  always #5 clk = ~clk;

  cke_powerup_seq uut (
    .clk(clk), .rst(rst), .sw_rst(sw_rst),
    .cfg_pre_units(cfg_pre_units), .cfg_post_units(cfg_post_units),
    .cfg_bl_code(cfg_bl_code), .cke(cke), .init_start(init_start),
    .init_done(init_done), .config_error(config_error), .burst_len(burst_len)
  );

  typedef struct {
    int    at;
    int    sig;
    int    val;
    string req;
  } exp_t;

  exp_t q[$];
  int   edge_n = 0;
  int   checks = 0;
  int   fails = 0;
  bit   done_flag = 1'b0;

  always @(posedge clk) edge_n <= edge_n + 1;

  function automatic int sig_val(int s);
    case (s)
      0: return int'(cke);
      1: return int'(init_start);
      2: return int'(init_done);
      3: return int'(config_error);
      default: return int'(burst_len);
    endcase
  endfunction

  task automatic push(int at, int sig, int val, string req);
    exp_t e;
    e.at = at; e.sig = sig; e.val = val; e.req = req;
    q.push_back(e);
  endtask

  // monitor: compare expectations due at this edge
  always @(negedge clk) begin
    while (q.size() > 0 && q[0].at <= edge_n) begin
      exp_t it;
      it = q.pop_front();
      checks++;
      if (it.at < edge_n) begin
        fails++;
        $display("FAIL %s sig%0d missed edge %0d: actual %0d expected %0d",
                 it.req, it.sig, it.at, sig_val(it.sig), it.val);
      end else if (sig_val(it.sig) != it.val) begin
        fails++;
        $display("FAIL %s sig%0d at edge %0d: actual %0d expected %0d",
                 it.req, it.sig, it.at, sig_val(it.sig), it.val);
      end
    end
  end

  task automatic wait_drain();
    while (q.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  function automatic int bl_of(logic [3:0] c);
    case (c)
      4'b0010: return 4;
      4'b0100: return 8;
      4'b1000: return 16;
      default: return 0;
    endcase
  endfunction

  // expected sequence from release edge t0
  task automatic expect_seq(int t0, int pre, int post, logic [3:0] code, string req);
    int p = (pre == 0) ? 1 : pre * 1024;
    int qd = (post == 0) ? 1 : post * 1024;
    int s = t0 + p + qd;
    int bl = bl_of(code);
    push(t0, 4, bl, "R6");
    push(t0, 3, (bl == 0) ? 1 : 0, "R7");
    push(t0, 0, 0, "R2");
    push(t0 + p - 1, 0, 0, req);
    push(t0 + p, 0, 1, req);
    if (bl != 0) begin
      push(s - 1, 1, 0, "R3");
      push(s, 1, 1, "R3");
      push(s, 2, 0, "R5");
      push(s + 1, 1, 0, "R5");
      push(s + 1, 2, 1, "R5");
      push(s + 6, 2, 1, "R5");
      push(s + 6, 4, bl, "R8");
    end else begin
      push(s + 4, 1, 0, "R7");
      push(s + 4, 2, 0, "R7");
      push(s + 4, 3, 1, "R7");
      push(s + 4, 0, 1, "R7");
    end
  endtask

  task automatic apply_sw_reset(logic [9:0] pre, logic [9:0] post, logic [3:0] code);
    @(negedge clk);
    sw_rst = 1'b1;
    cfg_pre_units = pre; cfg_post_units = post; cfg_bl_code = code;
    @(negedge clk);
    push(edge_n + 1, 0, 0, "R9");
    push(edge_n + 1, 1, 0, "R9");
    push(edge_n + 1, 2, 0, "R9");
    push(edge_n + 1, 3, 0, "R9");
    @(negedge clk);
  endtask

  task automatic run(logic [9:0] pre, logic [9:0] post, logic [3:0] code,
                     bit scramble, string req);
    int t0;
    apply_sw_reset(pre, post, code);
    sw_rst = 1'b0;
    t0 = edge_n + 1;
    expect_seq(t0, int'(pre), int'(post), code, req);
    if (scramble) begin
      @(negedge clk);
      @(negedge clk);
      cfg_pre_units = pre + 10'd5; cfg_post_units = 10'd0; cfg_bl_code = 4'b0011;
    end
    wait_drain();
  endtask

  // R9: reset sampled on the edge the start pulse would fire
  task automatic collide();
    int t0;
    int s;
    apply_sw_reset(10'd0, 10'd1, 4'b1000);
    sw_rst = 1'b0;
    t0 = edge_n + 1;
    s = t0 + 1 + 1024;
    push(s - 1, 0, 1, "R9");
    push(s - 1, 1, 0, "R9");
    while (edge_n < s - 1) @(negedge clk);
    sw_rst = 1'b1;
    push(s, 1, 0, "R9");
    push(s, 0, 0, "R9");
    push(s, 2, 0, "R9");
    push(s + 2, 1, 0, "R9");
    @(negedge clk);
    @(negedge clk);
    @(negedge clk);
    wait_drain();
  endtask

  initial begin
    int t0;
    repeat (3) @(negedge clk);
    push(edge_n + 1, 0, 0, "R1");
    push(edge_n + 1, 1, 0, "R1");
    push(edge_n + 1, 2, 0, "R1");
    push(edge_n + 1, 3, 0, "R1");
    push(edge_n + 1, 4, 8, "R1");
    @(negedge clk);
    rst = 1'b0;
    t0 = edge_n + 1;
    push(t0, 4, 8, "R1");
    expect_seq(t0, 3, 2, 4'b0100, "R10");
    wait_drain();

    run(10'd1, 10'd1, 4'b0010, 1'b0, "R2");
    run(10'd0, 10'd0, 4'b0100, 1'b0, "R4");
    run(10'd0, 10'd1, 4'b1000, 1'b0, "R4");
    run(10'd2, 10'd0, 4'b0010, 1'b0, "R2");
    run(10'd1, 10'd1, 4'b0011, 1'b0, "R7");
    run(10'd1, 10'd2, 4'b0100, 1'b1, "R8");
    collide();
    run(10'd1, 10'd0, 4'b1000, 1'b0, "R9");

    done_flag = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  always @(negedge clk) begin
    if (!done_flag && edge_n > 100000) begin
      checks++;
      fails++;
      $display("FAIL watchdog at edge %0d: actual hung expected finished", edge_n);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule